// File: doc/BRIEF.md
# Synthetic Traffic Destination Selector

This block sits beside each node's packet source in a network-on-chip traffic generator. When the source asks for a new packet, the block answers with the destination node. The answer depends on the node's own address and on one of four synthetic traffic patterns. The node count is a power of two, `2**ADDR_W`. Uniform random destinations come from an internal linear-feedback shift register. The two permutation patterns (bit reversal and matrix transpose) and the single-hot-node pattern are fixed mappings of the address bits.

A one-cycle request starts a lookup. The block answers with a one-cycle destination-valid pulse. If the pattern maps the node onto itself, there is no destination to send to, so the block raises a one-cycle no-send pulse instead. In uniform mode a random draw that equals the node's own address is thrown away, and a new draw is taken on the following cycle.

The block also turns a configured injection rate, given in flits per cycle as a fixed-point fraction, together with the packet length, into a whole number of idle cycles to insert between adjacent packets.

Top module: `traffic_dest_sel`

## Requirements
- R1: While reset is asserted, `dst_valid` and `no_send` are 0 and `gap_cycles` is 0.
- R2: Pattern code 0 (uniform) never yields the node's own address. A draw that hits the node's own address is replaced by a fresh draw on the next cycle. The answer arrives within 31 cycles of acceptance.
- R3: Over repeated uniform requests, every node except the node itself is chosen at least once.
- R4: Pattern code 1 (bit reversal) returns the address with its bit order reversed: destination bit i equals source bit `ADDR_W-1-i`.
- R5: Pattern code 2 (transpose) swaps the two halves of the address: the destination is `{my_addr[ADDR_W/2-1:0], my_addr[ADDR_W-1:ADDR_W/2]}`.
- R6: Pattern code 3 (hot spot) returns `hot_addr`, as captured when the request was accepted.
- R7: When a permutation maps the node onto itself, or the node is itself the hot node in hot-spot mode, `no_send` pulses and `dst_valid` stays low.
- R8: For patterns 1 to 3, the answer (`dst_valid` or `no_send`) appears on the clock edge after the edge that accepted the request. The answer is a single-cycle pulse, and `dst_valid` and `no_send` are never high together.
- R9: A request is accepted only when no lookup is pending; requests arriving while one is pending are ignored. With `req` held high, patterns 1 to 3 answer once every two cycles.
- R10: One cycle after `pkt_len` or `rate_q` changes, `gap_cycles` equals floor(`pkt_len`·2^`RATE_FRAC`/`rate_q`) − `pkt_len`, limited below at 0. Here `rate_q` is a rate in units of 2^−`RATE_FRAC` flits per cycle.
- R11: A `rate_q` of 0 gives an all-ones `gap_cycles`. A rate at or above one flit per cycle gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_addr | input | ADDR_W | This node's address |
| mode | input | 2 | Pattern code: 0 uniform, 1 bit reversal, 2 transpose, 3 hot spot |
| hot_addr | input | ADDR_W | Hot node for pattern 3 |
| req | input | 1 | Request for one destination |
| pkt_len | input | LEN_W | Packet length in flits |
| rate_q | input | RATE_W | Injection rate, fixed point with RATE_FRAC fraction bits |
| dst_valid | output | 1 | One-cycle pulse: dst_addr holds a destination |
| dst_addr | output | ADDR_W | Chosen destination |
| no_send | output | 1 | One-cycle pulse: the node has no destination under this pattern |
| gap_cycles | output | GAP_W | Idle cycles between adjacent packets |

## Verification
The bench drives a request across one clock edge, which accepts it. It then samples at the falling edge after the next rising edge, where a fixed-pattern answer is due. It also checks the falling edge in between, to confirm the answer has not come early, and the falling edge after the answer, to confirm the pulse has ended. Uniform answers may come later, so the bench polls each falling edge up to a cycle limit and records the worst wait. Gap results are registered, so they are sampled one falling edge after the length or rate is changed. A held request is counted over a fixed window of edges to confirm that patterns 1 to 3 answer once every two cycles.

// File: rtl/tdsel_pkg.sv
`timescale 1ns/1ps
package tdsel_pkg;

  typedef enum logic [1:0] {
    PAT_UNIFORM   = 2'd0,
    PAT_BITREV    = 2'd1,
    PAT_TRANSPOSE = 2'd2,
    PAT_HOTSPOT   = 2'd3
  } pattern_e;

  // Idle cycles between packets: floor(len * 2^frac / rate) - len, floor 0.
  // A zero rate means "never inject" and returns all ones.
  function automatic logic [31:0] gap_from_rate(input logic [31:0] len,
                                                input logic [31:0] rate,
                                                input int unsigned frac);
    logic [63:0] num;
    logic [63:0] quo;
    if (rate == 32'd0) return '1;
    num = {32'd0, len} << frac;
    quo = num / {32'd0, rate};
    if (quo <= {32'd0, len}) return 32'd0;
    quo = quo - {32'd0, len};
    if (quo > 64'h0000_0000_FFFF_FFFF) return '1;
    return quo[31:0];
  endfunction

endpackage

// File: rtl/tdsel_lfsr.sv
`timescale 1ns/1ps
module tdsel_lfsr #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic fb;

  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEED;
    else        state <= {state[W-2:0], fb};
  end
endmodule

// File: rtl/tdsel_perm.sv
`timescale 1ns/1ps
module tdsel_perm #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] rev_dst,
  output logic [ADDR_W-1:0] tr_dst
);
  localparam int unsigned HALF = ADDR_W / 2;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_rev
    assign rev_dst[i] = src[ADDR_W-1-i];
  end

  // Lower half moves up, upper half moves down.
  assign tr_dst = {src[HALF-1:0], src[ADDR_W-1:HALF]};
endmodule

// File: rtl/tdsel_gap.sv
`timescale 1ns/1ps
module tdsel_gap #(
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned RATE_W    = 9,
  parameter int unsigned RATE_FRAC = 8,
  parameter int unsigned GAP_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [RATE_W-1:0] rate_q,
  output logic [GAP_W-1:0]  gap_cycles
);
  localparam logic [31:0] GAP_MAX = 32'((64'd1 << GAP_W) - 64'd1);

  logic [31:0] raw;
  logic [GAP_W-1:0] sat;

  assign raw = tdsel_pkg::gap_from_rate(32'(pkt_len), 32'(rate_q), RATE_FRAC);
  assign sat = (raw > GAP_MAX) ? GAP_MAX[GAP_W-1:0] : raw[GAP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) gap_cycles <= '0;
    else        gap_cycles <= sat;
  end
endmodule

// File: rtl/tdsel_ctrl.sv
`timescale 1ns/1ps
module tdsel_ctrl
  import tdsel_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  pattern_e          mode,
  input  logic [ADDR_W-1:0] hot_addr,
  input  logic [ADDR_W-1:0] my_addr,
  input  logic [ADDR_W-1:0] draw,
  input  logic [ADDR_W-1:0] rev_dst,
  input  logic [ADDR_W-1:0] tr_dst,
  output logic              dst_valid,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              no_send,
  output logic              busy,
  output pattern_e          mode_q,
  output logic [ADDR_W-1:0] hot_q,
  output logic              acc_evt,
  output logic              res_evt,
  output logic              resample_evt
);
  logic [ADDR_W-1:0] cand;
  logic              self_hit;

  always_comb begin
    unique case (mode_q)
      PAT_UNIFORM:   cand = draw;
      PAT_BITREV:    cand = rev_dst;
      PAT_TRANSPOSE: cand = tr_dst;
      default:       cand = hot_q;
    endcase
    self_hit = (cand == my_addr);
  end

  assign acc_evt      = req && !busy;
  assign resample_evt = busy && self_hit && (mode_q == PAT_UNIFORM);
  assign res_evt      = busy && !resample_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      mode_q    <= PAT_UNIFORM;
      hot_q     <= '0;
      dst_valid <= 1'b0;
      no_send   <= 1'b0;
      dst_addr  <= '0;
    end else begin
      dst_valid <= 1'b0;
      no_send   <= 1'b0;
      if (acc_evt) begin
        busy   <= 1'b1;
        mode_q <= mode;
        hot_q  <= hot_addr;
      end else if (res_evt) begin
        busy <= 1'b0;
        if (self_hit) begin
          no_send <= 1'b1;
        end else begin
          dst_valid <= 1'b1;
          dst_addr  <= cand;
        end
      end
    end
  end
endmodule

// File: rtl/traffic_dest_sel.sv
`timescale 1ns/1ps
module traffic_dest_sel
  import tdsel_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned RATE_W    = 9,
  parameter int unsigned RATE_FRAC = 8,
  parameter int unsigned GAP_W     = 16,
  parameter int unsigned LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] my_addr,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] hot_addr,
  input  logic              req,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [RATE_W-1:0] rate_q,
  output logic              dst_valid,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              no_send,
  output logic [GAP_W-1:0]  gap_cycles
);
  logic [LFSR_W-1:0] lfsr_state;
  logic [ADDR_W-1:0] draw;
  logic [ADDR_W-1:0] rev_dst;
  logic [ADDR_W-1:0] tr_dst;

  // Named internal events, observed by the bound checker.
  logic              busy;
  pattern_e          mode_q;
  logic [ADDR_W-1:0] hot_q;
  logic              acc_evt;
  logic              res_evt;
  logic              resample_evt;

  tdsel_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (lfsr_state)
  );

  assign draw = lfsr_state[ADDR_W-1:0];

  tdsel_perm #(.ADDR_W(ADDR_W)) u_perm (
    .src     (my_addr),
    .rev_dst (rev_dst),
    .tr_dst  (tr_dst)
  );

  tdsel_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .mode         (pattern_e'(mode)),
    .hot_addr     (hot_addr),
    .my_addr      (my_addr),
    .draw         (draw),
    .rev_dst      (rev_dst),
    .tr_dst       (tr_dst),
    .dst_valid    (dst_valid),
    .dst_addr     (dst_addr),
    .no_send      (no_send),
    .busy         (busy),
    .mode_q       (mode_q),
    .hot_q        (hot_q),
    .acc_evt      (acc_evt),
    .res_evt      (res_evt),
    .resample_evt (resample_evt)
  );

  tdsel_gap #(.LEN_W(LEN_W), .RATE_W(RATE_W), .RATE_FRAC(RATE_FRAC),
              .GAP_W(GAP_W)) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_len    (pkt_len),
    .rate_q     (rate_q),
    .gap_cycles (gap_cycles)
  );
endmodule

// File: rtl/tdsel_chk.sv
`timescale 1ns/1ps
module tdsel_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned RATE_W = 9,
  parameter int unsigned GAP_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] my_addr,
  input logic [1:0]        mode,
  input logic [RATE_W-1:0] rate_q,
  input logic              dst_valid,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              no_send,
  input logic [GAP_W-1:0]  gap_cycles,
  input logic              busy,
  input logic [1:0]        mode_q,
  input logic [ADDR_W-1:0] hot_q,
  input logic              acc_evt,
  input logic              res_evt,
  input logic              resample_evt
);
  logic [7:0] wait_cnt;
  logic       rev_ok;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) wait_cnt <= '0;
    else if (wait_cnt != 8'hFF) wait_cnt <= wait_cnt + 8'd1;
  end

  always_comb begin
    rev_ok = 1'b1;
    for (int i = 0; i < ADDR_W; i++)
      if (dst_addr[i] != my_addr[ADDR_W-1-i]) rev_ok = 1'b0;
  end

  a_r2_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && mode_q == 2'd0) |-> (dst_addr != my_addr));

  a_r2_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (wait_cnt < 8'd32));

  a_r2_resample_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
    resample_evt |=> (busy && !dst_valid && !no_send));

  a_r4_bit_reverse: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && mode_q == 2'd1) |-> rev_ok);

  a_r6_hot_target: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && mode_q == 2'd3) |-> (dst_addr == hot_q));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dst_valid && no_send));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid || no_send) |=> (!dst_valid && !no_send));

  a_r8_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && mode != 2'd0) |=> res_evt);

  a_r8_answer_after_resolve: assert property (@(posedge clk) disable iff (!rst_n)
    res_evt |=> (dst_valid || no_send));

  a_r11_zero_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == '0) |=> (gap_cycles == '1));
endmodule

bind traffic_dest_sel tdsel_chk #(.ADDR_W(ADDR_W), .RATE_W(RATE_W), .GAP_W(GAP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .my_addr      (my_addr),
  .mode         (mode),
  .rate_q       (rate_q),
  .dst_valid    (dst_valid),
  .dst_addr     (dst_addr),
  .no_send      (no_send),
  .gap_cycles   (gap_cycles),
  .busy         (busy),
  .mode_q       (mode_q),
  .hot_q        (hot_q),
  .acc_evt      (acc_evt),
  .res_evt      (res_evt),
  .resample_evt (resample_evt)
);

// File: tb/tb_traffic_dest_sel.sv
`timescale 1ns/1ps
module tb_traffic_dest_sel;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] my_addr;
  logic [1:0] mode;
  logic [3:0] hot_addr;
  logic       req;
  logic [7:0] pkt_len;
  logic [8:0] rate_q;
  logic       dst_valid;
  logic [3:0] dst_addr;
  logic       no_send;
  logic [15:0] gap_cycles;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  traffic_dest_sel dut (
    .clk(clk), .rst_n(rst_n), .my_addr(my_addr), .mode(mode),
    .hot_addr(hot_addr), .req(req), .pkt_len(pkt_len), .rate_q(rate_q),
    .dst_valid(dst_valid), .dst_addr(dst_addr), .no_send(no_send),
    .gap_cycles(gap_cycles)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One request for a fixed pattern; checks timing, returns the answer.
  task automatic one_req(input string tag, output logic v, output logic ns,
                         output logic [3:0] a);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    check(!dst_valid && !no_send, "R8", {tag, " early answer"},
          longint'(dst_valid | no_send), 0);
    @(negedge clk);
    v = dst_valid; ns = no_send; a = dst_addr;
    check(!(v && ns), "R8", {tag, " both pulses"}, longint'(v & ns), 0);
    @(negedge clk);
    check(!dst_valid && !no_send, "R8", {tag, " pulse length"},
          longint'(dst_valid | no_send), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = 1'b0; my_addr = 4'd0; mode = 2'd0; hot_addr = 4'd0;
    pkt_len = 8'd4; rate_q = 9'd128;
    repeat (3) @(negedge clk);
    check(dst_valid == 1'b0, "R1", "dst_valid in reset", longint'(dst_valid), 0);
    check(no_send == 1'b0, "R1", "no_send in reset", longint'(no_send), 0);
    check(gap_cycles == 16'd0, "R1", "gap in reset", longint'(gap_cycles), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_bitrev();
    logic v, ns; logic [3:0] a;
    logic [3:0] exp_a;
    mode = 2'd1;
    for (int s = 0; s < 16; s++) begin
      my_addr = 4'(s);
      exp_a = {my_addr[0], my_addr[1], my_addr[2], my_addr[3]};
      one_req("R4", v, ns, a);
      if (exp_a == my_addr) begin
        check(ns && !v, "R7", "bitrev fixed point no_send", longint'(ns), 1);
      end else begin
        check(v && !ns, "R4", "bitrev valid", longint'(v), 1);
        check(a == exp_a, "R4", "bitrev address", longint'(a), longint'(exp_a));
      end
    end
  endtask

  task automatic t_transpose();
    logic v, ns; logic [3:0] a;
    logic [3:0] exp_a;
    mode = 2'd2;
    for (int s = 0; s < 16; s++) begin
      my_addr = 4'(s);
      exp_a = {my_addr[1:0], my_addr[3:2]};
      one_req("R5", v, ns, a);
      if (exp_a == my_addr) begin
        check(ns && !v, "R7", "transpose fixed point no_send", longint'(ns), 1);
      end else begin
        check(v && !ns, "R5", "transpose valid", longint'(v), 1);
        check(a == exp_a, "R5", "transpose address", longint'(a), longint'(exp_a));
      end
    end
  endtask

  task automatic t_hotspot();
    logic v, ns; logic [3:0] a;
    mode = 2'd3; hot_addr = 4'd12;
    my_addr = 4'd3;
    one_req("R6", v, ns, a);
    check(v && a == 4'd12, "R6", "hot destination", longint'(a), 12);
    my_addr = 4'd9; hot_addr = 4'd0;
    one_req("R6", v, ns, a);
    check(v && a == 4'd0, "R6", "hot destination zero", longint'(a), 0);
    my_addr = 4'd12; hot_addr = 4'd12;
    one_req("R7", v, ns, a);
    check(ns && !v, "R7", "hot node itself no_send", longint'(ns), 1);
  endtask

  task automatic t_uniform();
    logic [15:0] seen = '0;
    int self_cnt = 0;
    int worst = 0;
    int ns_cnt = 0;
    mode = 2'd0; my_addr = 4'd5;
    for (int d = 0; d < 160; d++) begin
      int w = 0;
      bit got = 1'b0;
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
      while (!got && w < 40) begin
        @(negedge clk);
        w++;
        if (no_send) ns_cnt++;
        if (dst_valid) begin
          got = 1'b1;
          seen[dst_addr] = 1'b1;
          if (dst_addr == my_addr) self_cnt++;
        end
      end
      if (w > worst) worst = w;
    end
    check(self_cnt == 0, "R2", "uniform picked self", longint'(self_cnt), 0);
    check(worst <= 31, "R2", "uniform worst wait", longint'(worst), 31);
    check(ns_cnt == 0, "R2", "uniform no_send", longint'(ns_cnt), 0);
    check(seen == 16'hFFDF, "R3", "uniform coverage mask", longint'(seen), 16'hFFDF);
  endtask

  task automatic t_stream();
    int cnt = 0;
    mode = 2'd1; my_addr = 4'd1;
    @(negedge clk); req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (dst_valid) begin
        cnt++;
        check(dst_addr == 4'd8, "R9", "held req address", longint'(dst_addr), 8);
      end
    end
    req = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      if (dst_valid) cnt++;
    end
    check(cnt == 3, "R9", "answers for held req", longint'(cnt), 3);
  endtask

  task automatic gap_case(input logic [7:0] len, input logic [8:0] rate,
                          input string tag, input logic [15:0] exp_g);
    @(negedge clk); pkt_len = len; rate_q = rate;
    @(negedge clk);
    check(gap_cycles == exp_g, tag, "gap cycles", longint'(gap_cycles),
          longint'(exp_g));
  endtask

  task automatic t_gap();
    gap_case(8'd8,   9'd128, "R10", 16'd8);     // 0.5 flit/cycle: 16 - 8
    gap_case(8'd5,   9'd96,  "R10", 16'd8);     // 1280/96 = 13 -> 13 - 5
    gap_case(8'd200, 9'd1,   "R10", 16'd51000); // 51200 - 200
    gap_case(8'd3,   9'd85,  "R10", 16'd6);     // 768/85 = 9 -> 9 - 3
    gap_case(8'd4,   9'd0,   "R11", 16'hFFFF);  // zero rate
    gap_case(8'd6,   9'd256, "R11", 16'd0);     // exactly one flit/cycle
    gap_case(8'd6,   9'd300, "R11", 16'd0);     // above one flit/cycle
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    t_reset();
    t_bitrev();
    t_transpose();
    t_hotspot();
    t_uniform();
    t_stream();
    t_gap();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end
endmodule